// File: doc/BRIEF.md
# Floating-Point to Integer Converter

This block turns one IEEE-754 operand, either single or double precision, into an integer. The integer can be signed or unsigned and 32 or 64 bits wide. Rounding is to nearest with ties to even unless the truncate control is set, in which case the fraction is dropped toward zero. Out-of-range values, infinities and NaNs saturate to fixed codes and raise the invalid flag. An in-range result that lost fraction bits raises the inexact flag.

Operands arrive on a valid/ready stream and results leave on a second valid/ready stream one clock later. An operand is taken on any edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result and flags are held unchanged and no new operand is taken. The precision select, destination type and truncate bit are sampled together with the operand.

Top module: `fp_to_int_cvt`

## Requirements
- R1: With `in_chop` low, the value is rounded to the nearest integer, and exact halves go to the even neighbour (2.5 gives 2, 3.5 gives 4, 0.5 gives 0).
- R2: With `in_chop` high, the fraction is discarded toward zero (2.75 gives 2, -2.75 gives -2, 0.9 gives 0).
- R3: For an unsigned destination, the sign is tested before any rounding. Any negative non-NaN input that is not zero gives 0 and raises invalid, even when its magnitude would round to zero. This holds in both rounding modes and for both precisions. Negative zero gives 0 and raises no flag.
- R4: For a signed destination, a NaN gives all ones (-1) and raises invalid, in both modes and for both precisions.
- R5: For an unsigned destination, a NaN gives all ones at the destination width and raises invalid. A 32-bit destination therefore gives 0x00000000FFFFFFFF.
- R6: A positive value whose rounded magnitude exceeds the destination maximum, and +infinity, give that maximum and raise invalid. A value equal to the maximum is exact and raises no flag.
- R7: For a signed destination, a negative value whose rounded magnitude exceeds 2^31 (32-bit) or 2^63 (64-bit), and -infinity, give the destination minimum and raise invalid. The minimum itself converts exactly and raises no flag.
- R8: The flag vector is `out_flags[4:0]`: bit 0 is invalid, bit 4 is inexact, and bits 1 to 3 are always 0. An in-range result that dropped non-zero fraction bits raises only inexact. An exact result raises nothing. Invalid and inexact are never raised together.
- R9: `in_dst` encodes the destination as follows: 00 is signed 32, 01 is unsigned 32, 10 is signed 64, 11 is unsigned 64. A 32-bit result is sign-extended (signed) or zero-extended (unsigned) to 64 bits on `out_result`.
- R10: `in_src_dbl` high takes all 64 operand bits as double precision. Low takes `in_operand[31:0]` as single precision, and bits 63:32 have no effect.
- R11: A taken operand appears on the output on the next clock edge. After reset `out_valid` is 0 and `in_ready` is 1. While `out_valid` is high and `out_ready` is low, `in_ready` is 0 and the result and flags stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Operand will be taken this cycle |
| in_operand | input | 64 | Floating-point bits (single uses bits 31:0) |
| in_src_dbl | input | 1 | 1 = double precision, 0 = single |
| in_dst | input | 2 | Destination type code |
| in_chop | input | 1 | 1 = truncate toward zero |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_result | output | 64 | Integer result, extended to 64 bits |
| out_flags | output | 5 | Exception flags |

## Verification
Most of the state is the output register, so a wrong internal value shows up at the ports on the edge after the operand is taken. A faulty alignment shift, guard or sticky bit shows as an integer off by one, or as a wrong inexact bit, on that same result. A wrong check order between sign, NaN and range shows as a saturation code or invalid flag where a plain value was expected. Stalls are driven while a second operand waits, so a register that fails to hold, or takes the waiting operand early, shows a changed result within one cycle.

// File: rtl/f2i_pkg.sv
`timescale 1ns/1ps
package f2i_pkg;
  localparam int INT_W   = 64;
  localparam int HALF_W  = INT_W / 2;
  localparam int MANT_W  = 53;
  localparam int EXP_W   = 13;
  localparam int SP_EW   = 8;
  localparam int SP_FW   = 23;
  localparam int DP_EW   = 11;
  localparam int DP_FW   = 52;
  localparam int FLAG_W  = 5;
  localparam int FLG_INVALID = 0;
  localparam int FLG_INEXACT = 4;

  typedef enum logic [1:0] {
    DST_S32 = 2'b00,
    DST_U32 = 2'b01,
    DST_S64 = 2'b10,
    DST_U64 = 2'b11
  } dst_e;

  typedef struct packed {
    logic                    sign;
    logic                    nan;
    logic                    inf;
    logic                    zero;
    logic signed [EXP_W-1:0] exp;
    logic [MANT_W-1:0]       mant;
  } fp_unpacked_t;
endpackage

// File: rtl/f2i_decode.sv
`timescale 1ns/1ps
module f2i_decode import f2i_pkg::*; #(
  parameter int EW = 8,
  parameter int FW = 23
) (
  input  logic [EW+FW:0] raw,
  output fp_unpacked_t   unp
);
  localparam int BIAS_I = (1 << (EW - 1)) - 1;
  localparam logic signed [EXP_W-1:0] BIAS    = EXP_W'(BIAS_I);
  localparam logic signed [EXP_W-1:0] DEN_EXP = EXP_W'(1 - BIAS_I);
  localparam int PAD = MANT_W - 1 - FW;

  logic [EW-1:0] efield;
  logic [FW-1:0] ffield;
  logic          e_ones, e_none, f_nz;

  always_comb begin
    efield   = raw[EW+FW-1:FW];
    ffield   = raw[FW-1:0];
    e_ones   = &efield;
    e_none   = ~|efield;
    f_nz     = |ffield;
    unp.sign = raw[EW+FW];
    unp.nan  = e_ones & f_nz;
    unp.inf  = e_ones & ~f_nz;
    unp.zero = e_none & ~f_nz;
    unp.exp  = e_none ? DEN_EXP
                      : ($signed({{(EXP_W-EW){1'b0}}, efield}) - BIAS);
    unp.mant = MANT_W'({~e_none, ffield}) << PAD;
  end
endmodule

// File: rtl/f2i_round.sv
`timescale 1ns/1ps
module f2i_round import f2i_pkg::*; (
  input  logic [MANT_W-1:0]       mant,
  input  logic signed [EXP_W-1:0] exp,
  input  logic                    chop,
  output logic [INT_W:0]          mag,
  output logic                    huge,
  output logic                    inexact
);
  localparam int AW   = 2 * INT_W;
  localparam int SH_W = $clog2(INT_W);
  localparam logic signed [EXP_W-1:0] TOP_E = EXP_W'(INT_W - 1);

  logic [AW-1:0]    aligned;
  logic [INT_W-1:0] ipart;
  logic [SH_W-1:0]  sh;
  logic             guard, sticky, up;

  always_comb begin
    aligned = '0;
    ipart   = '0;
    guard   = 1'b0;
    sticky  = 1'b0;
    sh      = SH_W'(TOP_E - exp);
    huge    = (exp > TOP_E);
    if (!huge && !exp[EXP_W-1]) begin
      aligned = {mant, {(AW-MANT_W){1'b0}}} >> sh;
      ipart   = aligned[AW-1:INT_W];
      guard   = aligned[INT_W-1];
      sticky  = |aligned[INT_W-2:0];
    end else if (exp == '1) begin
      guard  = mant[MANT_W-1];
      sticky = |mant[MANT_W-2:0];
    end else if (!huge) begin
      sticky = |mant;
    end
    up      = ~chop & guard & (sticky | ipart[0]);
    mag     = {1'b0, ipart} + (INT_W+1)'(up);
    inexact = guard | sticky;
  end
endmodule

// File: rtl/f2i_saturate.sv
`timescale 1ns/1ps
module f2i_saturate import f2i_pkg::*; (
  input  logic              sign,
  input  logic              nan,
  input  logic              inf,
  input  logic              zero,
  input  logic              huge,
  input  logic [INT_W:0]    mag,
  input  logic              inexact,
  input  dst_e              dst,
  output logic [INT_W-1:0]  result,
  output logic [FLAG_W-1:0] flags
);
  localparam logic [INT_W:0] ONE     = (INT_W+1)'(1);
  localparam logic [INT_W:0] S32_MAX = (ONE << (HALF_W-1)) - ONE;
  localparam logic [INT_W:0] S32_NEG = ONE << (HALF_W-1);
  localparam logic [INT_W:0] U32_MAX = (ONE << HALF_W) - ONE;
  localparam logic [INT_W:0] S64_MAX = (ONE << (INT_W-1)) - ONE;
  localparam logic [INT_W:0] S64_NEG = ONE << (INT_W-1);
  localparam logic [INT_W:0] U64_MAX = (ONE << INT_W) - ONE;

  logic             is64, uns;
  logic [INT_W:0]   pos_lim, neg_lim;
  logic [INT_W-1:0] sval;

  always_comb begin
    is64    = dst[1];
    uns     = dst[0];
    pos_lim = is64 ? (uns ? U64_MAX : S64_MAX) : (uns ? U32_MAX : S32_MAX);
    neg_lim = is64 ? S64_NEG : S32_NEG;
    sval    = sign ? (INT_W'(0) - mag[INT_W-1:0]) : mag[INT_W-1:0];
    flags   = '0;
    result  = '0;
    if (nan) begin
      flags[FLG_INVALID] = 1'b1;
      result = (uns && !is64) ? {{HALF_W{1'b0}}, {HALF_W{1'b1}}} : '1;
    end else if (uns && sign && !zero) begin
      flags[FLG_INVALID] = 1'b1;
    end else if (!sign && (inf || huge || mag > pos_lim)) begin
      flags[FLG_INVALID] = 1'b1;
      result = pos_lim[INT_W-1:0];
    end else if (sign && (inf || huge || mag > neg_lim)) begin
      flags[FLG_INVALID] = 1'b1;
      result = INT_W'(0) - neg_lim[INT_W-1:0];
    end else begin
      flags[FLG_INEXACT] = inexact;
      if (is64)
        result = sval;
      else if (uns)
        result = {{HALF_W{1'b0}}, sval[HALF_W-1:0]};
      else
        result = {{HALF_W{sval[HALF_W-1]}}, sval[HALF_W-1:0]};
    end
  end
endmodule

// File: rtl/fp_to_int_cvt.sv
`timescale 1ns/1ps
module fp_to_int_cvt import f2i_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [INT_W-1:0]  in_operand,
  input  logic              in_src_dbl,
  input  logic [1:0]        in_dst,
  input  logic              in_chop,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [INT_W-1:0]  out_result,
  output logic [FLAG_W-1:0] out_flags
);
  fp_unpacked_t     unp_sp, unp_dp, unp;
  logic [INT_W:0]   mag;
  logic             huge, inexact, take;
  logic [INT_W-1:0] res_d;
  logic [FLAG_W-1:0] flg_d;

  f2i_decode #(.EW(SP_EW), .FW(SP_FW)) u_dec_sp (
    .raw (in_operand[SP_EW+SP_FW:0]),
    .unp (unp_sp)
  );

  f2i_decode #(.EW(DP_EW), .FW(DP_FW)) u_dec_dp (
    .raw (in_operand[DP_EW+DP_FW:0]),
    .unp (unp_dp)
  );

  assign unp = in_src_dbl ? unp_dp : unp_sp;

  f2i_round u_round (
    .mant    (unp.mant),
    .exp     (unp.exp),
    .chop    (in_chop),
    .mag     (mag),
    .huge    (huge),
    .inexact (inexact)
  );

  f2i_saturate u_sat (
    .sign    (unp.sign),
    .nan     (unp.nan),
    .inf     (unp.inf),
    .zero    (unp.zero),
    .huge    (huge),
    .mag     (mag),
    .inexact (inexact),
    .dst     (dst_e'(in_dst)),
    .result  (res_d),
    .flags   (flg_d)
  );

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_flags  <= '0;
    end else if (take) begin
      out_valid  <= 1'b1;
      out_result <= res_d;
      out_flags  <= flg_d;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/fp_to_int_cvt_chk.sv
`timescale 1ns/1ps
module fp_to_int_cvt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [63:0] in_operand,
  input logic        in_src_dbl,
  input logic [1:0]  in_dst,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_result,
  input logic [4:0]  out_flags
);
  logic op_sign, op_nan, op_zero, taken;

  always_comb begin
    taken   = in_valid & in_ready;
    op_sign = in_src_dbl ? in_operand[63] : in_operand[31];
    op_nan  = in_src_dbl ? (&in_operand[62:52] && |in_operand[51:0])
                         : (&in_operand[30:23] && |in_operand[22:0]);
    op_zero = in_src_dbl ? ~|in_operand[62:0] : ~|in_operand[30:0];
  end

  // R11
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_flags));

  // R11
  no_take_in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R8
  flag_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_flags[3:1] == 3'b000) && !(out_flags[0] && out_flags[4]));

  // R3
  neg_to_unsigned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken && in_dst[0] && op_sign && !op_nan && !op_zero
      |=> out_valid && out_result == 64'd0 && out_flags == 5'b00001);

  // R4
  nan_to_signed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken && !in_dst[0] && op_nan
      |=> out_valid && out_result == '1 && out_flags == 5'b00001);

  // R11
  result_next_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> out_valid);
endmodule

bind fp_to_int_cvt fp_to_int_cvt_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_operand (in_operand),
  .in_src_dbl (in_src_dbl),
  .in_dst     (in_dst),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_flags  (out_flags)
);

// File: tb/sim_fp_to_int_cvt.sv
`timescale 1ns/1ps
module sim_fp_to_int_cvt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_operand = '0;
  logic        in_src_dbl = 1'b0;
  logic [1:0]  in_dst = 2'b00;
  logic        in_chop = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_result;
  logic [4:0]  out_flags;

  int applied = 0;
  int miscompares = 0;

  localparam logic [1:0] S32 = 2'b00, U32 = 2'b01, S64 = 2'b10, U64 = 2'b11;
  localparam logic [4:0] F_NONE = 5'b00000, F_INV = 5'b00001, F_INX = 5'b10000;

  always #2 clk = ~clk;

  fp_to_int_cvt u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_operand(in_operand), .in_src_dbl(in_src_dbl), .in_dst(in_dst),
    .in_chop(in_chop), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_flags(out_flags)
  );

  function automatic logic [63:0] d(input real r);
    return $realtobits(r);
  endfunction

  task automatic check(input string req, input logic ok_v, input logic [63:0] exp_r,
                       input logic [4:0] exp_f);
    applied++;
    if (!ok_v || out_result !== exp_r || out_flags !== exp_f) begin
      miscompares++;
      $display("FAIL %s: valid=%b result=%h flags=%b expected result=%h flags=%b",
               req, ok_v, out_result, out_flags, exp_r, exp_f);
    end
  endtask

  task automatic cvt(input string req, input logic [63:0] op, input logic dbl,
                     input logic [1:0] dst, input logic chop,
                     input logic [63:0] exp_r, input logic [4:0] exp_f);
    @(negedge clk);
    in_operand = op; in_src_dbl = dbl; in_dst = dst; in_chop = chop;
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, out_valid, exp_r, exp_f);
  endtask

  task automatic t_reset;
    applied++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      miscompares++;
      $display("FAIL R11 reset: out_valid=%b in_ready=%b expected 0 1", out_valid, in_ready);
    end
  endtask

  task automatic t_round_even;
    cvt("R1 2.5", d(2.5), 1, S32, 0, 64'd2, F_INX);
    cvt("R1 3.5", d(3.5), 1, S32, 0, 64'd4, F_INX);
    cvt("R1 0.5", d(0.5), 1, S64, 0, 64'd0, F_INX);
    cvt("R1 -2.5", d(-2.5), 1, S64, 0, 64'hFFFF_FFFF_FFFF_FFFE, F_INX);
    cvt("R1 single 1.5", 64'h3FC0_0000, 0, U32, 0, 64'd2, F_INX);
    cvt("R1 0.9", d(0.9), 1, S32, 0, 64'd1, F_INX);
  endtask

  task automatic t_chop;
    cvt("R2 2.75", d(2.75), 1, S32, 1, 64'd2, F_INX);
    cvt("R2 -2.75", d(-2.75), 1, S32, 1, 64'hFFFF_FFFF_FFFF_FFFE, F_INX);
    cvt("R2 0.9", d(0.9), 1, U64, 1, 64'd0, F_INX);
  endtask

  task automatic t_neg_unsigned;
    cvt("R3 tiny single u32", 64'hAB98_FBA8, 0, U32, 0, 64'd0, F_INV);
    cvt("R3 tiny single u64 chop", 64'hAB98_FBA8, 0, U64, 1, 64'd0, F_INV);
    cvt("R3 tiny double u64", 64'hBD73_1F75_0000_0000, 1, U64, 0, 64'd0, F_INV);
    cvt("R3 tiny double u32 chop", 64'hBD73_1F75_0000_0000, 1, U32, 1, 64'd0, F_INV);
    cvt("R3 -1.0 u64", d(-1.0), 1, U64, 0, 64'd0, F_INV);
    cvt("R3 -0 u32", 64'h8000_0000_0000_0000, 1, U32, 0, 64'd0, F_NONE);
  endtask

  task automatic t_nan_signed;
    cvt("R4 single nan s32", 64'h7FC0_0000, 0, S32, 0, '1, F_INV);
    cvt("R4 single nan s64 chop", 64'h7FC0_0000, 0, S64, 1, '1, F_INV);
    cvt("R4 double nan s32 chop", 64'h7FF8_0000_0000_0000, 1, S32, 1, '1, F_INV);
    cvt("R4 double nan s64", 64'h7FF8_0000_0000_0000, 1, S64, 0, '1, F_INV);
  endtask

  task automatic t_nan_unsigned;
    cvt("R5 double nan u32", 64'h7FF8_0000_0000_0000, 1, U32, 0, 64'h0000_0000_FFFF_FFFF, F_INV);
    cvt("R5 single nan u64", 64'h7FC0_0000, 0, U64, 0, '1, F_INV);
  endtask

  task automatic t_pos_sat;
    cvt("R6 3e9 s32", d(3.0e9), 1, S32, 0, 64'h0000_0000_7FFF_FFFF, F_INV);
    cvt("R6 +inf single u64", 64'h7F80_0000, 0, U64, 0, '1, F_INV);
    cvt("R6 2^32 u32", d(4294967296.0), 1, U32, 0, 64'h0000_0000_FFFF_FFFF, F_INV);
    cvt("R6 u32 max exact", d(4294967295.0), 1, U32, 0, 64'h0000_0000_FFFF_FFFF, F_NONE);
    cvt("R6 round carry u32", d(4294967295.5), 1, U32, 0, 64'h0000_0000_FFFF_FFFF, F_INV);
    cvt("R6 1e19 s64", d(1.0e19), 1, S64, 0, 64'h7FFF_FFFF_FFFF_FFFF, F_INV);
    cvt("R6 1e19 u64", d(1.0e19), 1, U64, 0, 64'h8AC7_2304_89E8_0000, F_NONE);
  endtask

  task automatic t_neg_sat;
    cvt("R7 -3e9 s32", d(-3.0e9), 1, S32, 0, 64'hFFFF_FFFF_8000_0000, F_INV);
    cvt("R7 s32 min exact", d(-2147483648.0), 1, S32, 0, 64'hFFFF_FFFF_8000_0000, F_NONE);
    cvt("R7 -inf s64", 64'hFFF0_0000_0000_0000, 1, S64, 0, 64'h8000_0000_0000_0000, F_INV);
  endtask

  task automatic t_flags;
    cvt("R8 exact 7.0", d(7.0), 1, S64, 0, 64'd7, F_NONE);
    cvt("R8 inexact only", d(12.25), 1, U64, 0, 64'd12, F_INX);
  endtask

  task automatic t_extend;
    cvt("R9 -5 s32 sign-extended", d(-5.0), 1, S32, 0, 64'hFFFF_FFFF_FFFF_FFFB, F_NONE);
    cvt("R9 3e9 u32 zero-extended", d(3.0e9), 1, U32, 0, 64'h0000_0000_B2D0_5E00, F_NONE);
  endtask

  task automatic t_src_select;
    cvt("R10 upper bits ignored", {32'hDEAD_BEEF, 32'h40E0_0000}, 0, S32, 0, 64'd7, F_NONE);
    cvt("R10 upper bits ignored neg", {32'hFFFF_FFFF, 32'hC0A0_0000}, 0, S64, 0,
        64'hFFFF_FFFF_FFFF_FFFB, F_NONE);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 1'b0;
    in_operand = d(7.0); in_src_dbl = 1; in_dst = S32; in_chop = 0; in_valid = 1'b1;
    @(negedge clk);
    in_operand = d(9.0);
    applied++;
    if (in_ready !== 1'b0) begin
      miscompares++;
      $display("FAIL R11 stall ready: in_ready=%b expected 0", in_ready);
    end
    check("R11 first result", out_valid, 64'd7, F_NONE);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R11 held under stall", out_valid, 64'd7, F_NONE);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R11 waiting operand taken", out_valid, 64'd9, F_NONE);
    @(negedge clk);
    applied++;
    if (out_valid !== 1'b0) begin
      miscompares++;
      $display("FAIL R11 drain: out_valid=%b expected 0", out_valid);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_round_even();
    t_chop();
    t_neg_unsigned();
    t_nan_signed();
    t_nan_unsigned();
    t_pos_sat();
    t_neg_sat();
    t_flags();
    t_extend();
    t_src_select();
    t_backpressure();
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end
endmodule